// File: doc/BRIEF.md
# RF Switch Control Register Bank

This block is the register set of a serial-bus slave that steers a four-way antenna switch. A frame engine in front of it decodes bus transactions and hands over one write request (a short form that only targets the switch-state register, or an extended form with a 5-bit address) and one read request per cycle. It also hands over a pulse vector of protocol error events. The bank answers reads combinationally in the same cycle and raises a flag when an address outside its defined set is touched. It drives a 3-bit path code and a low-power flag toward the switch drivers. It also exposes its unique and group slave IDs so that the frame engine can match addresses.

Switch-state writes may be staged in a shadow register and released later by a trigger write. The status register captures error events, which clear when the register is read. A software reset restores the switch-state and status logic but keeps the IDs and the power/trigger register. The unique ID can only be rewritten after an unlock sequence that quotes the product and manufacturer IDs.

Top module: `rfsw_regbank`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets the switch register to 0x00, the power mode to 10 (low power, `low_power`=1) and the trigger masks to 000. It sets the group ID to 0. It sets the unique ID to 4'hB when `id_sel`=0 and to 4'hA when `id_sel`=1.
- R2: `sw_state` equals bits 2:0 of the active switch register when they hold 0..4. Code 0 means isolation and codes 1..4 mean antenna to ports 1..4. Codes 5..7 are driven out as 0. A read of address 0x00 returns all 8 active bits.
- R3: A short write (`wr_short`=1) loads data bits 6:0 into the switch register and forces bit 7 to 0. An extended write to 0x00 loads bits 7:0.
- R4: While any trigger mask bit (0x1C bits 5:3) is 0, a switch write only loads the shadow register. The active register and `sw_state` keep their values.
- R5: An extended write to 0x1C with data bit i (i=0..2) set and data bit 3+i clear copies the shadow register to the active register at that edge. With all masks at 1, switch writes load the active register directly. Bits 2:0 of 0x1C always read 0.
- R6: Reads return fixed values: 0x10 returns 0x00, 0x1D returns 0x26 and 0x1E returns 0xB0. 0x1F returns 0 in bits 7:6 and 01 in bits 5:4. Writes do not alter these values.
- R7: Status register 0x1A captures `err_evt` bit j into bit j and holds it. The bit assignments are: 6 command parity, 5 command length, 4 address parity, 3 data parity, 2 read of unused register, 1 write to unused register, 0 broadcast/group ID error.
- R8: A read of 0x1A returns the captured bits and clears them at that edge. An event that arrives in the same cycle as the clearing read is kept.
- R9: An extended write to 0x1A with bit 7 set clears the active and shadow switch registers, the status bits and any unlock progress. Power mode, masks, group ID and unique ID are kept. Bit 7 reads 0.
- R10: Address 0x1B holds the group ID in bits 3:0. Bits 7:4 read 0.
- R11: Bits 7:6 of 0x1C hold the power mode: 00 active, 01 startup, 10 low power, 11 reserved. `low_power` is 1 only for code 10.
- R12: A write to 0x1F loads the unique ID from data bits 3:0 only if the two preceding writes were 0x1D with 0x26 and then 0x1E with 0xB0. Any other write in between, or any other order, leaves the ID unchanged.
- R13: An access to an address outside {0x00,0x10,0x1A..0x1F} raises `addr_invalid` in that cycle and returns read data 0. At the next edge it sets status bit 2 (read) or bit 1 (write), and it changes no other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request valid |
| wr_short | input | 1 | Short-form write to the switch register |
| wr_addr | input | 5 | Extended write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read request valid |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data, same cycle |
| addr_invalid | output | 1 | Current access targets an undefined address |
| err_evt | input | 7 | Protocol error event pulses from the frame engine |
| id_sel | input | 1 | Selects the unique ID default at reset |
| sw_state | output | 3 | Decoded switch path code |
| low_power | output | 1 | Power mode is low power |
| uid | output | 4 | Current unique slave ID |
| gid | output | 4 | Current group slave ID |

## Verification
The clearing read of the status register and a fresh error event can land in the same cycle. The bench provokes this by pulsing `err_evt` in the same cycle that it reads 0x1A with an older flag already pending. The read must show only the older flag, and the following read must show only the new one. A similar race exists between staging and release: the bench stages a value in the shadow register, then issues trigger writes with the matching mask both set and clear. It judges `sw_state` after each write.

// File: rtl/rfsw_pkg.sv
package rfsw_pkg;

    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int STATE_W = 3;
    localparam int TRIG_N  = 3;
    localparam int UID_W   = 4;
    localparam int GID_W   = 4;
    localparam int ERR_N   = 7;
    localparam int MAX_PATH = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam addr_t A_SW   = 5'h00;
    localparam addr_t A_REV  = 5'h10;
    localparam addr_t A_STAT = 5'h1A;
    localparam addr_t A_GRP  = 5'h1B;
    localparam addr_t A_PMT  = 5'h1C;
    localparam addr_t A_PROD = 5'h1D;
    localparam addr_t A_MFG  = 5'h1E;
    localparam addr_t A_UID  = 5'h1F;

    localparam byte_t       REV_VAL  = 8'h00;
    localparam byte_t       PROD_VAL = 8'h26;
    localparam byte_t       MFG_LO   = 8'hB0;
    localparam logic [1:0]  MFG_HI   = 2'b01;

    localparam int EB_WR_UNUSED = 1;
    localparam int EB_RD_UNUSED = 2;
    localparam int SWRST_BIT    = 7;

    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'b00,
        PM_STARTUP = 2'b01,
        PM_LOW     = 2'b10,
        PM_RSVD    = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        UL_IDLE = 2'b00,
        UL_PROD = 2'b01,
        UL_MFG  = 2'b10
    } unlock_e;

    typedef struct packed {
        pmode_e             pm;
        logic [TRIG_N-1:0]  mask;
    } pmt_t;

    function automatic logic addr_known(addr_t a);
        case (a)
            A_SW, A_REV, A_STAT, A_GRP, A_PMT, A_PROD, A_MFG, A_UID: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [STATE_W-1:0] path_decode(byte_t r);
        if (r[STATE_W-1:0] <= STATE_W'(MAX_PATH))
            return r[STATE_W-1:0];
        return '0;
    endfunction

endpackage

// File: rtl/rfsw_switch_ctl.sv
module rfsw_switch_ctl
    import rfsw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               ld,
    input  byte_t              ld_data,
    input  logic               armed,
    input  logic               fire_any,
    output byte_t              act_o,
    output logic [STATE_W-1:0] state_o
);

    byte_t act_q;
    byte_t shd_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            act_q <= '0;
            shd_q <= '0;
        end else begin
            if (ld) begin
                shd_q <= ld_data;
                if (!armed)
                    act_q <= ld_data;
            end
            if (fire_any)
                act_q <= shd_q;
        end
    end

    assign act_o   = act_q;
    assign state_o = path_decode(act_q);

endmodule

// File: rtl/rfsw_status.sv
module rfsw_status
    import rfsw_pkg::*;
#(
    parameter int N = ERR_N
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         soft_rst,
    input  logic         clr,
    input  logic [N-1:0] evt,
    output logic [N-1:0] stat_o
);

    logic [N-1:0] stat_q;

    for (genvar j = 0; j < N; j++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                stat_q[j] <= 1'b0;
            else
                stat_q[j] <= (stat_q[j] & ~(clr | soft_rst)) | evt[j];
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/rfsw_id_regs.sv
module rfsw_id_regs
    import rfsw_pkg::*;
#(
    parameter logic [UID_W-1:0] UID_LO = 4'hB,
    parameter logic [UID_W-1:0] UID_HI = 4'hA
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             id_sel,
    input  logic             wr_any,
    input  logic             wr_ext,
    input  addr_t            addr,
    input  byte_t            data,
    output pmt_t             pmt_o,
    output logic [GID_W-1:0] gid_o,
    output logic [UID_W-1:0] uid_o,
    output logic             unlocked_o
);

    pmt_t             pmt_q;
    logic [GID_W-1:0] gid_q;
    logic [UID_W-1:0] uid_q;
    unlock_e          ul_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pmt_q.pm   <= PM_LOW;
            pmt_q.mask <= '0;
            gid_q      <= '0;
        end else if (wr_ext) begin
            if (addr == A_PMT) begin
                pmt_q.pm   <= pmode_e'(data[DATA_W-1 -: 2]);
                pmt_q.mask <= data[2*TRIG_N-1:TRIG_N];
            end
            if (addr == A_GRP)
                gid_q <= data[GID_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            uid_q <= id_sel ? UID_HI : UID_LO;
            ul_q  <= UL_IDLE;
        end else if (soft_rst) begin
            ul_q  <= UL_IDLE;
        end else if (wr_any) begin
            ul_q <= UL_IDLE;
            if (wr_ext) begin
                if (addr == A_PROD && data == PROD_VAL)
                    ul_q <= UL_PROD;
                else if (addr == A_MFG && data == MFG_LO && ul_q == UL_PROD)
                    ul_q <= UL_MFG;
                else if (addr == A_UID && ul_q == UL_MFG)
                    uid_q <= data[UID_W-1:0];
            end
        end
    end

    assign pmt_o      = pmt_q;
    assign gid_o      = gid_q;
    assign uid_o      = uid_q;
    assign unlocked_o = (ul_q == UL_MFG);

endmodule

// File: rtl/rfsw_regbank.sv
module rfsw_regbank
    import rfsw_pkg::*;
#(
    parameter logic [UID_W-1:0] UID_SEL_LO = 4'hB,
    parameter logic [UID_W-1:0] UID_SEL_HI = 4'hA
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_short,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               addr_invalid,
    input  logic [ERR_N-1:0]   err_evt,
    input  logic               id_sel,
    output logic [STATE_W-1:0] sw_state,
    output logic               low_power,
    output logic [UID_W-1:0]   uid,
    output logic [GID_W-1:0]   gid
);

    logic              wr_ext;
    logic              sw_ld;
    byte_t             sw_ld_data;
    logic [TRIG_N-1:0] fire;
    logic              fire_any;
    logic              sw_armed;
    logic              soft_rst;
    logic              wr_undef;
    logic              rd_undef;
    logic [ERR_N-1:0]  stat_evt;
    logic              stat_clr;
    logic [ERR_N-1:0]  stat_q;
    byte_t             act_q;
    pmt_t              pmt_q;
    logic [GID_W-1:0]  gid_q;
    logic [UID_W-1:0]  uid_q;
    logic              unlocked;
    logic              uid_wr_bad;

    assign wr_ext     = wr_en & ~wr_short;
    assign sw_ld      = wr_en & (wr_short | (wr_addr == A_SW));
    assign sw_ld_data = wr_short ? {1'b0, wr_data[DATA_W-2:0]} : wr_data;
    assign soft_rst   = wr_ext & (wr_addr == A_STAT) & wr_data[SWRST_BIT];
    assign wr_undef   = wr_ext & ~addr_known(wr_addr);
    assign rd_undef   = rd_en & ~addr_known(rd_addr);
    assign stat_clr   = rd_en & (rd_addr == A_STAT);
    assign sw_armed   = ~&pmt_q.mask;
    assign uid_wr_bad = wr_ext & (wr_addr == A_UID) & ~unlocked;

    for (genvar i = 0; i < TRIG_N; i++) begin : g_trig
        assign fire[i] = wr_ext & (wr_addr == A_PMT)
                       & wr_data[i] & ~wr_data[TRIG_N+i];
    end
    assign fire_any = |fire;

    always_comb begin
        stat_evt = err_evt;
        stat_evt[EB_RD_UNUSED] = err_evt[EB_RD_UNUSED] | rd_undef;
        stat_evt[EB_WR_UNUSED] = err_evt[EB_WR_UNUSED] | wr_undef;
    end

    rfsw_switch_ctl u_sw (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .ld       (sw_ld),
        .ld_data  (sw_ld_data),
        .armed    (sw_armed),
        .fire_any (fire_any),
        .act_o    (act_q),
        .state_o  (sw_state)
    );

    rfsw_status #(.N(ERR_N)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .clr      (stat_clr),
        .evt      (stat_evt),
        .stat_o   (stat_q)
    );

    rfsw_id_regs #(.UID_LO(UID_SEL_LO), .UID_HI(UID_SEL_HI)) u_id (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .id_sel     (id_sel),
        .wr_any     (wr_en),
        .wr_ext     (wr_ext),
        .addr       (wr_addr),
        .data       (wr_data),
        .pmt_o      (pmt_q),
        .gid_o      (gid_q),
        .uid_o      (uid_q),
        .unlocked_o (unlocked)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rd_addr)
                A_SW:   rd_data = act_q;
                A_REV:  rd_data = REV_VAL;
                A_STAT: rd_data = {1'b0, stat_q};
                A_GRP:  rd_data = {{(DATA_W-GID_W){1'b0}}, gid_q};
                A_PMT:  rd_data = {pmt_q.pm, pmt_q.mask, {TRIG_N{1'b0}}};
                A_PROD: rd_data = PROD_VAL;
                A_MFG:  rd_data = MFG_LO;
                A_UID:  rd_data = {2'b00, MFG_HI, uid_q};
                default: rd_data = '0;
            endcase
        end
    end

    assign addr_invalid = wr_undef | rd_undef;
    assign low_power    = (pmt_q.pm == PM_LOW);
    assign uid          = uid_q;
    assign gid          = gid_q;

endmodule

// File: rtl/rfsw_regbank_chk.sv
module rfsw_regbank_chk
    import rfsw_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [DATA_W-1:0]  rd_data,
    input logic               addr_invalid,
    input logic               low_power,
    input logic               sw_ld,
    input logic               sw_armed,
    input logic [DATA_W-1:0]  sw_ld_data,
    input logic               fire_any,
    input logic [DATA_W-1:0]  act_q,
    input logic [ERR_N-1:0]   stat_evt,
    input logic               stat_clr,
    input logic [ERR_N-1:0]   stat_q,
    input logic               soft_rst,
    input logic [GID_W-1:0]   gid,
    input logic [UID_W-1:0]   uid,
    input logic [1:0]         pm,
    input logic               wr_undef,
    input logic               uid_wr_bad
);

    assert_reset_lowpower_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> low_power);

    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (sw_ld && sw_armed && !soft_rst) |=> $stable(act_q));

    assert_direct_load_R5: assert property (@(posedge clk) disable iff (rst)
        (sw_ld && !sw_armed && !fire_any && !soft_rst) |=> act_q == $past(sw_ld_data));

    assert_product_const_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == A_PROD) |-> rd_data == PROD_VAL);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && stat_evt == '0) |=> stat_q == '0);

    assert_swreset_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> ($stable(gid) && $stable(uid) && $stable(pm)));

    assert_uid_guard_R12: assert property (@(posedge clk) disable iff (rst)
        uid_wr_bad |=> $stable(uid));

    assert_invalid_noop_R13: assert property (@(posedge clk) disable iff (rst)
        wr_undef |=> ($stable(act_q) && $stable(gid) && $stable(uid) && $stable(pm)));

    assert_invalid_flag_R13: assert property (@(posedge clk) disable iff (rst)
        addr_invalid |=> (stat_q[EB_RD_UNUSED] || stat_q[EB_WR_UNUSED]));

endmodule

bind rfsw_regbank rfsw_regbank_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .addr_invalid (addr_invalid),
    .low_power    (low_power),
    .sw_ld        (sw_ld),
    .sw_armed     (sw_armed),
    .sw_ld_data   (sw_ld_data),
    .fire_any     (fire_any),
    .act_q        (act_q),
    .stat_evt     (stat_evt),
    .stat_clr     (stat_clr),
    .stat_q       (stat_q),
    .soft_rst     (soft_rst),
    .gid          (gid_q),
    .uid          (uid_q),
    .pm           (pmt_q.pm),
    .wr_undef     (wr_undef),
    .uid_wr_bad   (uid_wr_bad)
);

// File: tb/rfsw_regbank_test.sv
module rfsw_regbank_test;

    localparam int CLK_P = 10;
    localparam int WATCHDOG_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_short = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       addr_invalid;
    logic [6:0] err_evt = '0;
    logic       id_sel = 1'b0;
    logic [2:0] sw_state;
    logic       low_power;
    logic [3:0] uid;
    logic [3:0] gid;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    rfsw_regbank uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_short(wr_short),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .addr_invalid(addr_invalid), .err_evt(err_evt),
        .id_sel(id_sel), .sw_state(sw_state), .low_power(low_power),
        .uid(uid), .gid(gid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic sel);
        @(negedge clk);
        id_sel = sel;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_short = 1'b0; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wrs(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_short = 1'b1; wr_addr = 5'h00; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_short = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d, output logic inv);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1;
        d = rd_data; inv = addr_invalid;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic inv;
        rd(a, d, inv);
        chk(req, d, exp);
    endtask

    task automatic pulse_evt(input logic [6:0] v);
        @(negedge clk);
        err_evt = v;
        @(negedge clk);
        err_evt = '0;
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        chk("R1 sw_state", sw_state, 0);
        chk("R1 low_power", low_power, 1);
        rd_chk("R1 switch reg", 5'h00, 8'h00);
        rd_chk("R1 pm/mask", 5'h1C, 8'h80);
        rd_chk("R1 R10 group id", 5'h1B, 8'h00);
        rd_chk("R1 R6 uid sel low", 5'h1F, 8'h1B);
        chk("R1 uid port", uid, 4'hB);
    endtask

    task automatic t_trigger;
        wr(5'h00, 8'h03);
        chk("R4 staged not active", sw_state, 0);
        rd_chk("R4 active readback", 5'h00, 8'h00);
        wr(5'h1C, 8'h81);
        chk("R5 fire trig0", sw_state, 3);
        rd_chk("R5 trig bits read 0", 5'h1C, 8'h80);
        wr(5'h00, 8'h02);
        chk("R4 staged again", sw_state, 3);
        wr(5'h1C, 8'h89);
        chk("R5 masked trigger no fire", sw_state, 3);
        wr(5'h1C, 8'h82);
        chk("R5 fire trig1", sw_state, 2);
    endtask

    task automatic t_direct;
        wr(5'h1C, 8'h38);
        chk("R11 active mode not low", low_power, 0);
        wr(5'h00, 8'h04);
        chk("R5 direct load", sw_state, 4);
        wrs(8'hFF);
        rd_chk("R3 short write bit7 zero", 5'h00, 8'h7F);
        chk("R2 code 7 isolates", sw_state, 0);
        wr(5'h00, 8'h85);
        rd_chk("R3 extended write 8 bits", 5'h00, 8'h85);
        chk("R2 code 5 isolates", sw_state, 0);
        wr(5'h00, 8'h01);
        chk("R2 path 1", sw_state, 1);
    endtask

    task automatic t_consts;
        rd_chk("R6 revision", 5'h10, 8'h00);
        rd_chk("R6 product", 5'h1D, 8'h26);
        rd_chk("R6 manufacturer", 5'h1E, 8'hB0);
        wr(5'h1D, 8'h55);
        rd_chk("R6 product write ignored", 5'h1D, 8'h26);
        wr(5'h10, 8'hFF);
        rd_chk("R6 revision write ignored", 5'h10, 8'h00);
    endtask

    task automatic t_status;
        logic [7:0] d;
        logic inv;
        rd(5'h1A, d, inv);
        pulse_evt(7'h41);
        rd_chk("R7 capture", 5'h1A, 8'h41);
        rd_chk("R8 clear on read", 5'h1A, 8'h00);
        pulse_evt(7'h7F);
        rd_chk("R7 all flags", 5'h1A, 8'h7F);
    endtask

    task automatic t_collide;
        pulse_evt(7'h40);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 5'h1A; err_evt = 7'h08;
        #1;
        chk("R8 read during event", rd_data, 8'h40);
        @(negedge clk);
        rd_en = 1'b0; err_evt = '0;
        rd_chk("R8 same-cycle event kept", 5'h1A, 8'h08);
        rd_chk("R8 then cleared", 5'h1A, 8'h00);
    endtask

    task automatic t_swreset;
        wr(5'h1B, 8'hF5);
        rd_chk("R10 group id upper zero", 5'h1B, 8'h05);
        chk("R10 gid port", gid, 4'h5);
        pulse_evt(7'h10);
        wr(5'h1A, 8'h80);
        chk("R9 switch cleared", sw_state, 0);
        rd_chk("R9 switch reg cleared", 5'h00, 8'h00);
        rd_chk("R9 status cleared", 5'h1A, 8'h00);
        rd_chk("R9 group kept", 5'h1B, 8'h05);
        rd_chk("R9 pm/mask kept", 5'h1C, 8'h38);
        rd_chk("R9 uid kept", 5'h1F, 8'h1B);
    endtask

    task automatic t_pm;
        wr(5'h1C, 8'h78);
        chk("R11 startup", low_power, 0);
        wr(5'h1C, 8'hF8);
        chk("R11 reserved", low_power, 0);
        wr(5'h1C, 8'hB8);
        chk("R11 low power", low_power, 1);
        rd_chk("R11 readback", 5'h1C, 8'hB8);
    endtask

    task automatic t_uid;
        wr(5'h1F, 8'h05);
        rd_chk("R12 no unlock", 5'h1F, 8'h1B);
        wr(5'h1D, 8'h26);
        wr(5'h1E, 8'hB0);
        wr(5'h1F, 8'h05);
        rd_chk("R12 unlocked write", 5'h1F, 8'h15);
        chk("R12 uid port", uid, 4'h5);
        wr(5'h1E, 8'hB0);
        wr(5'h1D, 8'h26);
        wr(5'h1F, 8'h07);
        rd_chk("R12 wrong order", 5'h1F, 8'h15);
        wr(5'h1D, 8'h26);
        wr(5'h1B, 8'h05);
        wr(5'h1E, 8'hB0);
        wr(5'h1F, 8'h09);
        rd_chk("R12 interrupted", 5'h1F, 8'h15);
    endtask

    task automatic t_invalid;
        logic [7:0] d;
        logic inv;
        rd(5'h1A, d, inv);
        @(negedge clk);
        wr_en = 1'b1; wr_short = 1'b0; wr_addr = 5'h05; wr_data = 8'hFF;
        #1;
        chk("R13 write flag", addr_invalid, 1);
        @(negedge clk);
        wr_en = 1'b0;
        rd_chk("R13 write unused bit", 5'h1A, 8'h02);
        rd(5'h07, d, inv);
        chk("R13 read data zero", d, 8'h00);
        chk("R13 read flag", inv, 1);
        rd_chk("R13 read unused bit", 5'h1A, 8'h04);
        rd_chk("R13 switch untouched", 5'h00, 8'h00);
        rd_chk("R13 group untouched", 5'h1B, 8'h05);
        rd_chk("R13 pm untouched", 5'h1C, 8'hB8);
        rd(5'h1E, d, inv);
        chk("R13 valid addr no flag", inv, 0);
    endtask

    task automatic t_sel;
        do_reset(1'b1);
        rd_chk("R1 uid sel high", 5'h1F, 8'h1A);
        chk("R1 uid port high", uid, 4'hA);
    endtask

    initial begin
        t_reset();
        t_trigger();
        t_direct();
        t_consts();
        t_status();
        t_collide();
        t_swreset();
        t_pm();
        t_uid();
        t_invalid();
        t_sel();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule